// File: doc/BRIEF.md
# Programmable Interval Timer Unit

This unit gives an embedded core a countdown timer. Software writes a period into a reload register. While enabled, the counter counts down by one on every time-base enable pulse. When the count would pass from 1 to 0 the timer expires. It then records an event in a status register, drives a level interrupt, and either starts the same period again or stops. A separate fixed-interval pulse input records its own event and can raise a second interrupt.

The unit decides again whether to run or stop after three events:
- a reload write, which does not look at auto-reload;
- a control write, which requires auto-reload;
- an expiry.

Status flags are sticky. Software clears them by writing ones. Writing a one to the top status bit also drops the interval interrupt. Access is through one write port and one combinational read port, each with a 2-bit register select.

Top module: `ivt_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped, and both interrupt outputs are low.
- R2: A control write stores only bits 31..22 of the data, and the other bits read back as zero. Bit 26 is the interval interrupt enable, bit 23 is the fixed-interval interrupt enable, and bit 22 is auto-reload.
- R3: A reload write stores the value and loads it into the count. The counter runs when the value is above 1 and control bit 26 is set; control bit 22 is not consulted. A running counter drops by one per tick_i pulse, and select 0 reads back the current count.
- R4: The counter does not change on ticks when the reload value is 0 or 1, or when control bit 26 is clear.
- R5: On the tick that finds a count of 1, status bit 27 is set, and pit_irq_o goes high and stays high.
- R6: At expiry the count reloads the stored value when control bit 22 is set, so expiries come exactly every reload-value ticks. Otherwise the count goes to 0 and the counter stops.
- R7: A control write stops the counter unless bits 26 and 22 of the new value are both set and the reload value is above 1. If the counter is already running and may continue, its count is kept unchanged. If it is stopped and may run, it starts from the reload value.
- R8: A status write clears each of bits 31..26 that is one in the data. The other bits of status stay unchanged, and bits 25..0 always read zero.
- R9: A status write with bit 31 set drops pit_irq_o. Clearing only bit 27 leaves pit_irq_o high.
- R10: A fixed_tick_i pulse sets status bit 26. It raises fit_irq_o when control bit 23 is set. Writing a one to status bit 26 drops fit_irq_o.
- R11: When an event and a write-one clear of the same status bit, or of the interrupt it raises, fall in the same cycle, the event wins.
- R12: The register select codes are: 0 for reload/count, 1 for control, 2 for status. Select 3 reads zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Time-base enable pulse, one count per cycle high |
| fixed_tick_i | input | 1 | Fixed-interval event pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select for writes |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 2 | Register select for reads |
| rd_data_o | output | 32 | Read data (combinational) |
| pit_irq_o | output | 1 | Interval timer interrupt, level |
| fit_irq_o | output | 1 | Fixed-interval interrupt, level |

## Verification
The hardest case to reach from the ports is an expiry landing in the same cycle as a software clear of the flag and of the interrupt it raises (R11). The bench gets there by running to a count of 1 with a short reload value. In the next cycle it drives a tick and a status write of ones together, and a fixed-interval pulse alongside. A second difficult point is a control write that arrives while the counter is mid-period (R7). It is checked by reading the count before and after the write and after one more tick.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int unsigned DW = 32;

  localparam logic [1:0] SEL_RELOAD = 2'd0;
  localparam logic [1:0] SEL_CTRL   = 2'd1;
  localparam logic [1:0] SEL_STAT   = 2'd2;

  // control bit positions
  localparam int unsigned BIT_PIT_IE = 26;
  localparam int unsigned BIT_FIT_IE = 23;
  localparam int unsigned BIT_AR     = 22;
  // status bit positions
  localparam int unsigned BIT_PIT_CLR_IRQ = 31;
  localparam int unsigned BIT_PIT_EV      = 27;
  localparam int unsigned BIT_FIT_EV      = 26;

  localparam int unsigned CTRL_LSB = 22;
  localparam int unsigned STAT_LSB = 26;
  localparam logic [DW-1:0] CTRL_MASK = {{(DW-CTRL_LSB){1'b1}}, {CTRL_LSB{1'b0}}};
  localparam logic [DW-1:0] STAT_MASK = {{(DW-STAT_LSB){1'b1}}, {STAT_LSB{1'b0}}};
endpackage

// File: rtl/ivt_ctrl_reg.sv
module ivt_ctrl_reg
  import ivt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] ctrl_nxt_o
);
  logic [DW-1:0] ctrl_q;

  assign ctrl_nxt_o = wr_i ? (wr_data_i & CTRL_MASK) : ctrl_q;
  assign ctrl_o     = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_nxt_o;
  end

  // R2
  ctrl_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> ctrl_o == ($past(wr_data_i) & CTRL_MASK));
  // R12
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(ctrl_o));
endmodule

// File: rtl/ivt_countdown.sv
module ivt_countdown
  import ivt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reload_wr_i,
  input  logic          ctrl_wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          ie_nxt_i,
  input  logic          ar_nxt_i,
  output logic [DW-1:0] count_o,
  output logic          expire_o
);
  logic [DW-1:0] reload_q, count_q;
  logic          running_q;
  logic          any_wr, reload_ok, at_one;

  assign any_wr    = reload_wr_i | ctrl_wr_i;
  assign reload_ok = reload_q > DW'(1);
  assign at_one    = count_q == DW'(1);
  assign expire_o  = running_q & tick_i & at_one & ~any_wr;
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q  <= '0;
      count_q   <= '0;
      running_q <= 1'b0;
    end else if (reload_wr_i) begin
      // auto-reload is not part of this decision
      reload_q  <= wr_data_i;
      count_q   <= wr_data_i;
      running_q <= (wr_data_i > DW'(1)) & ie_nxt_i;
    end else if (ctrl_wr_i) begin
      if (!(reload_ok && ie_nxt_i && ar_nxt_i)) begin
        running_q <= 1'b0;
      end else if (!running_q) begin
        running_q <= 1'b1;
        count_q   <= reload_q;
      end
    end else if (running_q && tick_i) begin
      if (at_one) begin
        if (ar_nxt_i && reload_ok) begin
          count_q <= reload_q;   // period restarts on the expiry tick itself
        end else begin
          count_q   <= '0;
          running_q <= 1'b0;
        end
      end else begin
        count_q <= count_q - DW'(1);
      end
    end
  end

  // R4
  run_needs_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> (reload_q > DW'(1)));
  // R4
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_q && !any_wr) |=> $stable(count_o));
  // R6
  auto_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && ar_nxt_i) |=> count_o == $past(reload_q));
  // R3
  decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_q && tick_i && !any_wr && !at_one) |=> count_o == $past(count_q) - DW'(1));
endmodule

// File: rtl/ivt_status_reg.sv
module ivt_status_reg
  import ivt_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          pit_set_i,
  input  logic          fit_set_i,
  input  logic          pit_ie_i,
  input  logic          fit_ie_i,
  output logic [DW-1:0] status_o,
  output logic          pit_irq_o,
  output logic          fit_irq_o
);
  logic [DW-1:0] status_q, clr_v, set_v;
  logic          pit_irq_q, fit_irq_q;

  always_comb begin
    clr_v = wr_i ? (wr_data_i & STAT_MASK) : '0;
    set_v = '0;
    set_v[BIT_PIT_EV] = pit_set_i;
    set_v[BIT_FIT_EV] = fit_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= '0;
      pit_irq_q <= 1'b0;
      fit_irq_q <= 1'b0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;   // set wins over clear
      if (pit_set_i && pit_ie_i)       pit_irq_q <= 1'b1;
      else if (clr_v[BIT_PIT_CLR_IRQ]) pit_irq_q <= 1'b0;
      if (fit_set_i && fit_ie_i)       fit_irq_q <= 1'b1;
      else if (clr_v[BIT_FIT_EV])      fit_irq_q <= 1'b0;
    end
  end

  assign status_o  = status_q;
  assign pit_irq_o = pit_irq_q;
  assign fit_irq_o = fit_irq_q;

  // R5
  pit_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pit_set_i |=> status_o[BIT_PIT_EV]);
  // R5
  pit_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pit_set_i && pit_ie_i) |=> pit_irq_o);
  // R8
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !pit_set_i && !fit_set_i) |=> (status_o & ($past(wr_data_i) & STAT_MASK)) == '0);
  // R9
  pit_irq_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wr_data_i[BIT_PIT_CLR_IRQ] && !(pit_set_i && pit_ie_i)) |=> !pit_irq_o);
  // R10
  fit_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fit_set_i && fit_ie_i) |=> fit_irq_o);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int unsigned DATA_W = DW,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              fixed_tick_i,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              pit_irq_o,
  output logic              fit_irq_o
);
  logic          reload_wr, ctrl_wr, stat_wr, expire;
  logic [DW-1:0] ctrl_q, ctrl_nxt, count, status;

  assign reload_wr = wr_en_i && (wr_sel_i == SEL_RELOAD);
  assign ctrl_wr   = wr_en_i && (wr_sel_i == SEL_CTRL);
  assign stat_wr   = wr_en_i && (wr_sel_i == SEL_STAT);

  ivt_ctrl_reg u_ctrl (
    .clk_i, .rst_ni,
    .wr_i       (ctrl_wr),
    .wr_data_i  (wr_data_i),
    .ctrl_o     (ctrl_q),
    .ctrl_nxt_o (ctrl_nxt)
  );

  ivt_countdown u_cnt (
    .clk_i, .rst_ni,
    .tick_i      (tick_i),
    .reload_wr_i (reload_wr),
    .ctrl_wr_i   (ctrl_wr),
    .wr_data_i   (wr_data_i),
    .ie_nxt_i    (ctrl_nxt[BIT_PIT_IE]),
    .ar_nxt_i    (ctrl_nxt[BIT_AR]),
    .count_o     (count),
    .expire_o    (expire)
  );

  ivt_status_reg u_stat (
    .clk_i, .rst_ni,
    .wr_i      (stat_wr),
    .wr_data_i (wr_data_i),
    .pit_set_i (expire),
    .fit_set_i (fixed_tick_i),
    .pit_ie_i  (ctrl_q[BIT_PIT_IE]),
    .fit_ie_i  (ctrl_q[BIT_FIT_IE]),
    .status_o  (status),
    .pit_irq_o (pit_irq_o),
    .fit_irq_o (fit_irq_o)
  );

  always_comb begin
    case (rd_sel_i)
      SEL_RELOAD: rd_data_o = count;
      SEL_CTRL:   rd_data_o = ctrl_q;
      SEL_STAT:   rd_data_o = status;
      default:    rd_data_o = '0;
    endcase
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pit_irq_o) |-> $past(expire));
endmodule

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, fix = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_sel = '0, rd_sel = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        pit_irq, fit_irq;
  int checks = 0, fails = 0;

  localparam logic [31:0] IE = 32'h0400_0000, AR = 32'h0040_0000, FE = 32'h0080_0000;
  localparam logic [31:0] ST_PIT = 32'h0800_0000, ST_FIT = 32'h0400_0000, ST_TOP = 32'h8000_0000;

  always #10 clk = ~clk;

  ivt_timer u_ivt_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fixed_tick_i(fix),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .pit_irq_o(pit_irq), .fit_irq_o(fit_irq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    rd_sel = s; #1; v = rd_data;
  endtask

  task automatic chk_reg(string req, logic [1:0] s, logic [31:0] exp);
    logic [31:0] v;
    rd(s, v); check(req, v, exp);
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk_reg("R1 count", 2'd0, 0);
    chk_reg("R1 ctrl", 2'd1, 0);
    chk_reg("R1 status", 2'd2, 0);
    check("R1 pit_irq", {31'd0, pit_irq}, 0);
    check("R1 fit_irq", {31'd0, fit_irq}, 0);
  endtask

  task automatic t_ctrl_mask;
    wr(2'd1, 32'hFFFF_FFFF);
    chk_reg("R2 ctrl mask", 2'd1, 32'hFFC0_0000);
    wr(2'd1, 32'h0);
    chk_reg("R2 ctrl clear", 2'd1, 0);
  endtask

  task automatic t_sel3;
    wr(2'd3, 32'hFFFF_FFFF);
    chk_reg("R12 ctrl untouched", 2'd1, 0);
    chk_reg("R12 count untouched", 2'd0, 0);
    chk_reg("R12 status untouched", 2'd2, 0);
    chk_reg("R12 sel3 reads zero", 2'd3, 0);
  endtask

  task automatic t_stopped;
    wr(2'd1, IE);
    wr(2'd0, 1); ticks(3);
    chk_reg("R4 reload one holds", 2'd0, 1);
    wr(2'd0, 0); ticks(3);
    chk_reg("R4 reload zero holds", 2'd0, 0);
    check("R4 no irq", {31'd0, pit_irq}, 0);
    wr(2'd1, 0);
    wr(2'd0, 5); ticks(3);
    chk_reg("R4 ie clear holds", 2'd0, 5);
    chk_reg("R4 no event", 2'd2, 0);
  endtask

  task automatic t_oneshot;
    wr(2'd1, IE);
    wr(2'd0, 4);
    chk_reg("R3 load", 2'd0, 4);
    ticks(1);
    chk_reg("R3 decrement", 2'd0, 3);
    ticks(2);
    chk_reg("R3 at one", 2'd0, 1);
    check("R5 no irq before expiry", {31'd0, pit_irq}, 0);
    ticks(1);
    chk_reg("R6 stop at zero", 2'd0, 0);
    chk_reg("R5 status flag", 2'd2, ST_PIT);
    check("R5 irq high", {31'd0, pit_irq}, 1);
    ticks(2);
    chk_reg("R6 stays stopped", 2'd0, 0);
    check("R5 irq stays", {31'd0, pit_irq}, 1);
    wr(2'd2, ST_PIT);
    chk_reg("R8 flag cleared", 2'd2, 0);
    check("R9 irq kept without bit31", {31'd0, pit_irq}, 1);
    wr(2'd2, ST_TOP);
    check("R9 irq dropped", {31'd0, pit_irq}, 0);
  endtask

  task automatic t_autoreload;
    wr(2'd1, IE | AR);
    wr(2'd0, 3);
    ticks(3);
    chk_reg("R6 reload on expiry", 2'd0, 3);
    check("R5 irq autoreload", {31'd0, pit_irq}, 1);
    wr(2'd2, 32'hFFFF_FFFF);
    chk_reg("R8 all cleared", 2'd2, 0);
    ticks(2);
    chk_reg("R6 second period", 2'd0, 1);
    ticks(1);
    chk_reg("R6 second expiry flag", 2'd2, ST_PIT);
    chk_reg("R6 second reload", 2'd0, 3);
    wr(2'd2, ST_PIT | ST_TOP);
  endtask

  task automatic t_ctrl_write;
    wr(2'd1, IE | AR);
    wr(2'd0, 5);
    ticks(2);
    chk_reg("R7 mid period", 2'd0, 3);
    wr(2'd1, IE | AR);
    chk_reg("R7 running keeps count", 2'd0, 3);
    ticks(1);
    chk_reg("R7 continues", 2'd0, 2);
    wr(2'd1, IE);
    ticks(2);
    chk_reg("R7 stop without auto-reload", 2'd0, 2);
    wr(2'd1, IE | AR);
    chk_reg("R7 restart from reload", 2'd0, 5);
    ticks(1);
    chk_reg("R7 restarted runs", 2'd0, 4);
    wr(2'd1, 0);
    ticks(2);
    chk_reg("R7 stop on ie clear", 2'd0, 4);
  endtask

  task automatic t_fit;
    @(negedge clk); fix = 1'b1; @(negedge clk); fix = 1'b0;
    chk_reg("R10 flag without enable", 2'd2, ST_FIT);
    check("R10 no irq without enable", {31'd0, fit_irq}, 0);
    wr(2'd2, ST_FIT);
    wr(2'd1, FE);
    @(negedge clk); fix = 1'b1; @(negedge clk); fix = 1'b0;
    check("R10 irq raised", {31'd0, fit_irq}, 1);
    chk_reg("R10 flag set", 2'd2, ST_FIT);
    wr(2'd2, ST_FIT);
    check("R10 irq cleared", {31'd0, fit_irq}, 0);
    chk_reg("R10 flag cleared", 2'd2, 0);
  endtask

  task automatic t_race;
    wr(2'd1, IE | AR | FE);
    wr(2'd0, 3);
    ticks(2);
    @(negedge clk);
    tick = 1'b1; fix = 1'b1;
    wr_en = 1'b1; wr_sel = 2'd2; wr_data = ST_TOP | ST_PIT | ST_FIT;
    @(negedge clk);
    tick = 1'b0; fix = 1'b0; wr_en = 1'b0;
    chk_reg("R11 flags survive clear", 2'd2, ST_PIT | ST_FIT);
    check("R11 pit irq survives", {31'd0, pit_irq}, 1);
    check("R11 fit irq survives", {31'd0, fit_irq}, 1);
    wr(2'd1, 0);
    wr(2'd2, ST_TOP | ST_PIT | ST_FIT);
    chk_reg("R8 final clear", 2'd2, 0);
  endtask

  initial begin
    #1; t_reset;
    #40 rst_n = 1'b1;
    t_reset;
    t_ctrl_mask;
    t_sel3;
    t_stopped;
    t_oneshot;
    t_autoreload;
    t_ctrl_write;
    t_fit;
    t_race;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule